// File: doc/BRIEF.md
# Wave Channel Length Counter

This block times how long a wave playback channel may sound. Software writes an 8-bit length field; the counter takes the complement of that field against 256, so the channel plays for between 1 and 256 length clocks. Once length gating is enabled, every clock from the external frame sequencer moves the count one step toward zero. When the count reaches zero, the block raises a one-cycle disable strobe that the channel logic uses to silence itself.

Two irregular behaviours are modelled. The first covers a control write that turns length gating on between sequencer steps, while the qualifier flag says the next step will not clock the length. That write removes one count at once. The second covers a trigger that finds the count at zero: it restores a full count of 256, or 255 when the same write enables length gating and the qualifier is set. Within one register write, the enable-edge step comes before the trigger reload.

Top module: `wave_len_counter`

## Requirements
- R1: A pulse on `len_wr` loads `len_count` with 256 minus `len_val`; the new value is visible after the clock edge that samples the write.
- R2: A `len_tick` while length gating is enabled and `len_count` is nonzero lowers the count by one.
- R3: A `len_tick` leaves `len_count` unchanged while length gating is disabled, or while the count is already zero.
- R4: When a decrement brings the count to zero, `chan_off` is high for exactly the one cycle in which `len_count` first reads zero; `chan_off` is never high while the count is nonzero.
- R5: A `ctl_wr` with `ctl_len_en`=1, made while gating was disabled, with `extra_ok`=1 and a nonzero count, lowers the count by one at once. Without `extra_ok`, or with gating already enabled, the write does not change the count.
- R6: If that enable-edge step brings the count to zero and the same write does not trigger, `chan_off` pulses.
- R7: A `ctl_wr` with `ctl_trig`=1 leaves a nonzero count unchanged and reloads a zero count to 256; the count never exceeds 256.
- R8: A trigger that finds the count at zero reloads 255 instead of 256 when the same write has `ctl_len_en`=1 and `extra_ok`=1.
- R9: In a single write, the enable-edge step is applied before the trigger. A count of 1 is first stepped to zero and then reloaded, and `chan_off` does not pulse.
- R10: In a single cycle the sequencer tick is applied first, then a length load, which replaces the ticked value, then the control write.
- R11: After reset `len_count` is 0, `chan_off` is 0 and length gating is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_wr | input | 1 | Length field write strobe |
| len_val | input | 8 | Length field value |
| ctl_wr | input | 1 | Frequency/trigger control write strobe |
| ctl_len_en | input | 1 | Length gating enable carried by the control write |
| ctl_trig | input | 1 | Trigger bit carried by the control write |
| len_tick | input | 1 | Length clock from the frame sequencer |
| extra_ok | input | 1 | Next sequencer step will not clock length |
| len_count | output | 9 | Current count, 0 to 256 |
| chan_off | output | 1 | One-cycle channel disable strobe |

## Verification
The enable-edge step and the trigger reload can land in the same control write, and a sequencer tick can land in that same cycle as well. The bench prepares counts of 0, 1, 2, 5 and 256 with gating both on and off beforehand. For each prepared state it issues one cycle with every combination of enable, trigger, qualifier and tick. It then compares the resulting count and strobe with values worked out from the ordering rule: tick first, then edge step, then reload. The count-of-one case shows the edge step reaching zero and the reload replacing it without a strobe.

// File: rtl/wlc_pkg.sv
package wlc_pkg;

  // Counter value after a length field write.
  function automatic int unsigned wlc_load_count(int unsigned max_cnt, int unsigned len_field);
    return max_cnt - len_field;
  endfunction

  // Value restored by a trigger that finds the counter empty.
  function automatic int unsigned wlc_reload_count(int unsigned max_cnt, logic extra, logic en);
    return (extra && en) ? (max_cnt - 1) : max_cnt;
  endfunction

endpackage

// File: rtl/wlc_dec_stage.sv
module wlc_dec_stage #(
  parameter int CNT_W = 9
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             fire_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_zero_o
);
  logic nonzero;

  assign nonzero    = (cnt_i != '0);
  assign cnt_o      = (fire_i && nonzero) ? cnt_i - CNT_W'(1) : cnt_i;
  assign hit_zero_o = fire_i && (cnt_i == CNT_W'(1));
endmodule

// File: rtl/wlc_trig_stage.sv
module wlc_trig_stage
  import wlc_pkg::*;
#(
  parameter int          CNT_W   = 9,
  parameter int unsigned MAX_CNT = 256
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             trig_i,
  input  logic             extra_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reloaded_o
);
  logic [CNT_W-1:0] reload_val;

  assign reload_val = CNT_W'(wlc_reload_count(MAX_CNT, extra_i, en_i));
  assign reloaded_o = trig_i && (cnt_i == '0);
  assign cnt_o      = reloaded_o ? reload_val : cnt_i;
endmodule

// File: rtl/wave_len_counter.sv
module wave_len_counter
  import wlc_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_val,
  input  logic             ctl_wr,
  input  logic             ctl_len_en,
  input  logic             ctl_trig,
  input  logic             len_tick,
  input  logic             extra_ok,
  output logic [LEN_W:0]   len_count,
  output logic             chan_off
);
  localparam int          CNT_W   = LEN_W + 1;
  localparam int unsigned MAX_CNT = 1 << LEN_W;

  logic [CNT_W-1:0] cnt_q, cnt_tick, cnt_load, cnt_edge, cnt_next;
  logic             en_q, off_q;
  logic             tick_fire, tick_hit, edge_evt, edge_fire, edge_hit;
  logic             trig_evt, reloaded, off_d;

  // Stage 1: sequencer tick on the stored count.
  assign tick_fire = len_tick && en_q;
  wlc_dec_stage #(.CNT_W(CNT_W)) u_tick (
    .cnt_i(cnt_q), .fire_i(tick_fire), .cnt_o(cnt_tick), .hit_zero_o(tick_hit)
  );

  // Stage 2: length field load replaces the ticked value.
  assign cnt_load = len_wr ? CNT_W'(wlc_load_count(MAX_CNT, 32'(len_val))) : cnt_tick;

  // Stage 3: extra step when gating turns on between sequencer steps.
  assign edge_evt  = ctl_wr && ctl_len_en && !en_q;
  assign edge_fire = edge_evt && extra_ok;
  wlc_dec_stage #(.CNT_W(CNT_W)) u_edge (
    .cnt_i(cnt_load), .fire_i(edge_fire), .cnt_o(cnt_edge), .hit_zero_o(edge_hit)
  );

  // Stage 4: trigger reload after the edge step.
  assign trig_evt = ctl_wr && ctl_trig;
  wlc_trig_stage #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_trig (
    .cnt_i(cnt_edge), .trig_i(trig_evt), .extra_i(extra_ok), .en_i(ctl_len_en),
    .cnt_o(cnt_next), .reloaded_o(reloaded)
  );

  assign off_d = (tick_hit || edge_hit) && (cnt_next == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      off_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next;
      off_q <= off_d;
      if (ctl_wr) en_q <= ctl_len_en;
    end
  end

  assign len_count = cnt_q;
  assign chan_off  = off_q;

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (len_wr && !ctl_wr) |=> (len_count == CNT_W'(MAX_CNT) - CNT_W'($past(len_val)))); // R1
  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (len_tick && !en_q && !len_wr && !ctl_wr) |=> $stable(len_count)); // R3
  AST_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    chan_off |-> (len_count == '0)); // R4
  AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_trig && !edge_evt && !len_wr && !len_tick) |=> $stable(len_count)); // R5
  AST_TRIG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |=> (len_count != '0)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    len_count <= CNT_W'(MAX_CNT)); // R7
  AST_RELOAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    reloaded |=> (len_count >= CNT_W'(MAX_CNT - 1))); // R8
endmodule

// File: tb/wave_len_counter_test.sv
`timescale 1ns/1ps
module wave_len_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       len_wr = 1'b0, ctl_wr = 1'b0, ctl_len_en = 1'b0, ctl_trig = 1'b0;
  logic       len_tick = 1'b0, extra_ok = 1'b0;
  logic [7:0] len_val = '0;
  logic [8:0] len_count;
  logic       chan_off;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  wave_len_counter uut (
    .clk(clk), .rst_n(rst_n), .len_wr(len_wr), .len_val(len_val), .ctl_wr(ctl_wr),
    .ctl_len_en(ctl_len_en), .ctl_trig(ctl_trig), .len_tick(len_tick),
    .extra_ok(extra_ok), .len_count(len_count), .chan_off(chan_off)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: drive after the falling edge, sample just after the rising edge.
  task automatic cyc(bit lw, int lv, bit cw, bit ce, bit ct, bit tk, bit ex);
    @(negedge clk);
    len_wr = lw; len_val = 8'(lv); ctl_wr = cw; ctl_len_en = ce;
    ctl_trig = ct; len_tick = tk; extra_ok = ex;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  // Bench's own statement of one cycle from R2, R5, R7..R10.
  function automatic int model_cnt(int c, bit pe, bit ce, bit ct, bit tk, bit ex, output bit off);
    int  v = c;
    bit  hit = 0;
    if (tk && pe && v > 0) begin v = v - 1; hit = (v == 0); end
    if (ce && !pe && ex && v > 0) begin v = v - 1; hit = hit || (v == 0); end
    if (ct && v == 0) v = (ex && ce) ? 255 : 256;
    off = hit && (v == 0);
    return v;
  endfunction

  // Bring the counter to count c with gating state pe.
  task automatic prepare(int c, bit pe);
    if (c == 0) begin
      cyc(1, 255, 0, 0, 0, 0, 0);
      cyc(0, 0, 1, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 1, 0);
      cyc(0, 0, 1, pe, 0, 0, 0);
    end else begin
      cyc(0, 0, 1, pe, 0, 0, 0);
      cyc(1, 256 - c, 0, 0, 0, 0, 0);
    end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cvals[5] = '{0, 1, 2, 5, 256};
    repeat (3) @(posedge clk);
    #1;
    chk("R11 count after reset", len_count, 0);
    chk("R11 strobe after reset", chan_off, 0);
    rst_n = 1'b1;
    cyc(1, 200, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R11 gating off after reset, tick ignored", len_count, 56);

    // Load and drain sweep over every length field value.
    for (int l = 0; l < 256; l++) begin
      int n = 0;
      cyc(0, 0, 1, 0, 0, 0, 0);
      cyc(1, l, 0, 0, 0, 0, 0);
      chk("R1 load value", len_count, 256 - l);
      cyc(0, 0, 1, 1, 0, 0, 0);
      for (int k = 1; k <= 257; k++) begin
        cyc(0, 0, 0, 0, 0, 1, 0);
        n = k;
        if (chan_off) break;
      end
      chk("R2 ticks until empty", n, 256 - l);
      chk("R4 count zero with strobe", len_count, 0);
      cyc(0, 0, 0, 0, 0, 1, 0);
      chk("R3 tick at zero keeps count", len_count, 0);
      chk("R4 strobe lasts one cycle", chan_off, 0);
    end

    // R3: disabled gating ignores ticks.
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(1, 250, 0, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R3 ticks ignored while disabled", len_count, 6);
    chk("R3 no strobe while disabled", chan_off, 0);

    // R5: edge step, no step without qualifier, no step when already on.
    cyc(0, 0, 1, 1, 0, 0, 1);
    chk("R5 enable edge with qualifier steps", len_count, 5);
    cyc(0, 0, 1, 1, 0, 0, 1);
    chk("R5 already enabled, no step", len_count, 5);
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 0, 0, 0);
    chk("R5 edge without qualifier, no step", len_count, 5);

    // R6: edge step to zero pulses the strobe.
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(1, 255, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 0, 0, 1);
    chk("R6 edge step reaches zero", len_count, 0);
    chk("R6 edge step strobe", chan_off, 1);

    // R7 / R8: trigger reloads.
    cyc(0, 0, 1, 1, 1, 0, 0);
    chk("R7 trigger reloads empty to 256", len_count, 256);
    cyc(0, 0, 1, 1, 1, 0, 1);
    chk("R7 trigger leaves nonzero count", len_count, 256);
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(1, 255, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 1, 1, 1, 0, 1);
    chk("R8 short reload to 255", len_count, 255);

    // R9: edge step then reload in one write.
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(1, 255, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 1, 0, 1);
    chk("R9 edge then reload", len_count, 255);
    chk("R9 no strobe when reloaded", chan_off, 0);

    // R10: load replaces a same-cycle tick.
    cyc(0, 0, 1, 1, 0, 0, 0);
    cyc(1, 100, 0, 0, 0, 1, 0);
    chk("R10 load wins over tick", len_count, 156);

    // Same-cycle combinations of tick, edge step and trigger.
    foreach (cvals[i]) begin
      for (int pe = 0; pe < 2; pe++) begin
        for (int m = 0; m < 16; m++) begin
          bit ce = m[0], ct = m[1], tk = m[2], ex = m[3];
          bit off;
          int exp;
          prepare(cvals[i], pe[0]);
          chk("R10 prepared count", len_count, cvals[i]);
          exp = model_cnt(cvals[i], pe[0], ce, ct, tk, ex, off);
          cyc(0, 0, 1, ce, ct, tk, ex);
          chk("R9 combined write count", len_count, exp);
          chk("R9 combined write strobe", chan_off, int'(off));
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule